// File: doc/BRIEF.md
# Lane Mask Divergence Unit

This block holds the active-lane mask of a 64-lane vector engine, one bit per lane: bit i set means lane i executes. A scalar sequencer lowers structured control flow (if, else, end of construct, break, conditional break, loop-back and kill) into single operations on this unit. Each operation takes up to two 64-bit operands, updates the mask in one cycle and returns a 64-bit value. The sequencer keeps that value in a scalar register and passes it back in later as the saved operand.

No hardware stack is used. Each construct's parked lanes travel as a returned value, so the unit needs only and, or, xor and and-not on the mask. Flags derived from the new mask tell the sequencer when no lane is active. They also say whether a loop should branch back, and whether skipping a body is worth a jump (only for bodies of at least 12 instructions).

Operations arrive on a valid/ready stream and results leave on a second valid/ready stream that holds one result. An operation is accepted when `op_valid` and `op_ready` are both high. `op_ready` is low while an earlier result is still waiting (`res_valid` high, `res_ready` low). During that time the mask and the waiting result do not change. Control inputs and flag outputs are plain pins.

Top module: `lane_mask_unit`

## Requirements
- R1: After reset `lane_mask` is all ones, `res_valid` is 0, `loop_again` is 0, `mask_zero` is 0 and `op_ready` is 1.
- R2: Code 0 (if): the new mask is old mask AND `op_a`, and the result is old mask AND NOT `op_a`, which are the lanes parked for the else path.
- R3: Code 1 (else): the new mask is (old mask OR `op_a`) XOR old mask, and the result is the old mask, which are the lanes that ran the then path.
- R4: Code 2 (end of construct): the new mask is old mask OR `op_a`, and the result is the new mask.
- R5: Code 3 (break) returns old mask OR `op_b`, and code 4 (conditional break) returns `op_a` OR `op_b`; neither changes the mask.
- R6: Code 5 (loop): the new mask is old mask AND NOT `op_a`, and the result is the new mask. `loop_again` is 1 after it exactly when the new mask is non-zero. Any other accepted operation clears `loop_again`.
- R7: Code 6 (kill): if `op_a` bit 31 is set the mask becomes zero; otherwise it is unchanged. The result is the new mask.
- R8: `mask_zero` is 1 exactly when `lane_mask` is zero. `skip_hint` is 1 exactly when `mask_zero` is 1 and `body_len` is at least 12.
- R9: When no operation is accepted, the mask and `res_data` keep their values. Code 7 leaves the mask unchanged and returns it.
- R10: While `res_valid` is 1 and `res_ready` is 0, `op_ready` is 0 and `res_data` is held. An operation offered during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation |
| op_code | input | 3 | Operation code (0 if, 1 else, 2 end, 3 break, 4 conditional break, 5 loop, 6 kill, 7 none) |
| op_a | input | 64 | Condition, saved mask or kill constant |
| op_b | input | 64 | Accumulated break set |
| res_valid | output | 1 | Result waiting |
| res_ready | input | 1 | Sequencer takes the result |
| res_data | output | 64 | Returned mask value |
| body_len | input | 8 | Length of the body the sequencer may skip |
| lane_mask | output | 64 | Current active-lane mask |
| mask_zero | output | 1 | No lane active |
| loop_again | output | 1 | Last loop operation left lanes active |
| skip_hint | output | 1 | Skipping the body is worthwhile |

## Verification
An operation accepted at a clock edge updates the mask, the result, `res_valid` and `loop_again` at that same edge. `mask_zero` follows combinationally from the mask. `skip_hint` also reacts at once to `body_len`. The bench therefore drives inputs at the falling edge, lets exactly one rising edge pass and reads every output at the next falling edge. Stall cases hold `res_ready` low across several edges and check that nothing has changed.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [2:0] {
    OP_IF    = 3'd0,
    OP_ELSE  = 3'd1,
    OP_ENDC  = 3'd2,
    OP_BRK   = 3'd3,
    OP_IFBRK = 3'd4,
    OP_LOOP  = 3'd5,
    OP_KILL  = 3'd6,
    OP_NONE  = 3'd7
  } lms_op_e;
endpackage

// File: rtl/lms_mask_alu.sv
module lms_mask_alu
  import lms_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int KILL_BIT = 31
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [2:0]       code,
  input  logic [LANES-1:0] opnd_a,
  input  logic [LANES-1:0] opnd_b,
  output logic [LANES-1:0] nxt_mask,
  output logic [LANES-1:0] ret_val,
  output logic             is_loop
);
  lms_op_e op;
  logic [LANES-1:0] merged;

  always_comb begin
    op       = lms_op_e'(code);
    merged   = cur_mask | opnd_a;
    nxt_mask = cur_mask;
    ret_val  = cur_mask;
    is_loop  = 1'b0;
    unique case (op)
      OP_IF: begin
        nxt_mask = cur_mask & opnd_a;
        ret_val  = cur_mask & ~opnd_a;
      end
      OP_ELSE: begin
        nxt_mask = merged ^ cur_mask;
        ret_val  = cur_mask;
      end
      OP_ENDC: begin
        nxt_mask = merged;
        ret_val  = merged;
      end
      OP_BRK:   ret_val = cur_mask | opnd_b;
      OP_IFBRK: ret_val = opnd_a | opnd_b;
      OP_LOOP: begin
        nxt_mask = cur_mask & ~opnd_a;
        ret_val  = cur_mask & ~opnd_a;
        is_loop  = 1'b1;
      end
      OP_KILL: begin
        nxt_mask = opnd_a[KILL_BIT] ? '0 : cur_mask;
        ret_val  = opnd_a[KILL_BIT] ? '0 : cur_mask;
      end
      default: begin
        nxt_mask = cur_mask;
        ret_val  = cur_mask;
      end
    endcase
  end
endmodule

// File: rtl/lms_zero_tree.sv
module lms_zero_tree #(
  parameter int LANES = 64,
  parameter int CHUNK = 8
) (
  input  logic [LANES-1:0] vec,
  output logic             any_set
);
  localparam int NCHUNK = LANES / CHUNK;
  logic [NCHUNK-1:0] part;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign part[g] = |vec[g*CHUNK +: CHUNK];
  end

  assign any_set = |part;
endmodule

// File: rtl/lms_skip_judge.sv
module lms_skip_judge #(
  parameter int LEN_W    = 8,
  parameter int SKIP_MIN = 12
) (
  input  logic             none_active,
  input  logic [LEN_W-1:0] len,
  output logic             worth_skip
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(SKIP_MIN);
  assign worth_skip = none_active && (len >= MIN_LEN);
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
  import lms_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int CHUNK    = 8,
  parameter int LEN_W    = 8,
  parameter int SKIP_MIN = 12,
  parameter int KILL_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_code,
  input  logic [LANES-1:0] op_a,
  input  logic [LANES-1:0] op_b,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [LANES-1:0] res_data,
  input  logic [LEN_W-1:0] body_len,
  output logic [LANES-1:0] lane_mask,
  output logic             mask_zero,
  output logic             loop_again,
  output logic             skip_hint
);
  logic [LANES-1:0] mask_q, nxt_mask, ret_val, res_q;
  logic             rv_q, loop_q, is_loop, any_set, accept;

  assign op_ready = !rv_q || res_ready;
  assign accept   = op_valid && op_ready;

  lms_mask_alu #(.LANES(LANES), .KILL_BIT(KILL_BIT)) u_alu (
    .cur_mask (mask_q),
    .code     (op_code),
    .opnd_a   (op_a),
    .opnd_b   (op_b),
    .nxt_mask (nxt_mask),
    .ret_val  (ret_val),
    .is_loop  (is_loop)
  );

  lms_zero_tree #(.LANES(LANES), .CHUNK(CHUNK)) u_zero (
    .vec     (mask_q),
    .any_set (any_set)
  );

  lms_skip_judge #(.LEN_W(LEN_W), .SKIP_MIN(SKIP_MIN)) u_skip (
    .none_active (!any_set),
    .len         (body_len),
    .worth_skip  (skip_hint)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      res_q  <= '0;
      rv_q   <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      if (accept) begin
        mask_q <= nxt_mask;
        res_q  <= ret_val;
        rv_q   <= 1'b1;
        loop_q <= is_loop && (nxt_mask != '0);
      end else if (res_ready) begin
        rv_q   <= 1'b0;
      end
    end
  end

  assign lane_mask  = mask_q;
  assign res_data   = res_q;
  assign res_valid  = rv_q;
  assign loop_again = loop_q;
  assign mask_zero  = !any_set;
endmodule

// File: rtl/lane_mask_unit_chk.sv
module lane_mask_unit_chk #(
  parameter int LANES    = 64,
  parameter int LEN_W    = 8,
  parameter int SKIP_MIN = 12,
  parameter int KILL_BIT = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [2:0]       op_code,
  input logic [LANES-1:0] op_a,
  input logic [LANES-1:0] op_b,
  input logic             res_valid,
  input logic             res_ready,
  input logic [LANES-1:0] res_data,
  input logic [LEN_W-1:0] body_len,
  input logic [LANES-1:0] lane_mask,
  input logic             mask_zero,
  input logic             loop_again,
  input logic             skip_hint
);
  logic acc;
  assign acc = op_valid && op_ready;

  p_if_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 3'd0 |=> lane_mask == ($past(lane_mask) & $past(op_a)));
  p_if_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 3'd0 |=> res_data == ($past(lane_mask) & ~$past(op_a)));
  p_else_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 3'd1 |=> res_data == $past(lane_mask));
  p_ifbrk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 3'd4 |=> res_data == ($past(op_a) | $past(op_b)) && $stable(lane_mask));
  p_loop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 3'd5 |=> loop_again == (lane_mask != '0));
  p_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 3'd6 && op_a[KILL_BIT] |=> lane_mask == '0);
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_zero == (lane_mask == '0));
  p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hint |-> mask_zero && body_len >= LEN_W'(SKIP_MIN));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(lane_mask));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !op_ready);
endmodule

bind lane_mask_unit lane_mask_unit_chk #(
  .LANES(LANES), .LEN_W(LEN_W), .SKIP_MIN(SKIP_MIN), .KILL_BIT(KILL_BIT)
) u_chk (.*);

// File: tb/lane_mask_unit_tb_top.sv
module lane_mask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = 3'd7;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic [7:0]  body_len = 8'd0;
  logic [63:0] lane_mask;
  logic        mask_zero, loop_again, skip_hint;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_mask_unit dut_i (.*);

  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] COND = 64'h0000_0000_FFFF_0000;
  localparam logic [63:0] LO   = 64'h0000_0000_FFFF_FFFF;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mask", lane_mask, ONES);
    chk("R1 res_valid", 64'(res_valid), 64'd0);
    chk("R1 loop_again", 64'(loop_again), 64'd0);
    chk("R1 mask_zero", 64'(mask_zero), 64'd0);
    chk("R1 op_ready", 64'(op_ready), 64'd1);
  endtask

  task automatic t_if_else_end;
    issue(3'd0, COND, '0);
    chk("R2 mask", lane_mask, COND);
    chk("R2 ret", res_data, ~COND);
    chk("R2 res_valid", 64'(res_valid), 64'd1);
    issue(3'd1, ~COND, '0);
    chk("R3 mask", lane_mask, ~COND);
    chk("R3 ret", res_data, COND);
    issue(3'd2, COND, '0);
    chk("R4 mask", lane_mask, ONES);
    chk("R4 ret", res_data, ONES);
  endtask

  task automatic t_breaks;
    issue(3'd0, LO, '0);
    issue(3'd3, '0, 64'h0000_0001_0000_0000);
    chk("R5 brk ret", res_data, 64'h0000_0001_FFFF_FFFF);
    chk("R5 brk mask", lane_mask, LO);
    issue(3'd4, 64'h0F, 64'hF0_0000);
    chk("R5 ifbrk ret", res_data, 64'hF0_000F);
    chk("R5 ifbrk mask", lane_mask, LO);
    issue(3'd2, ~LO, '0);
    chk("R4 restore", lane_mask, ONES);
  endtask

  task automatic t_loop;
    issue(3'd5, LO, '0);
    chk("R6 mask", lane_mask, ~LO);
    chk("R6 ret", res_data, ~LO);
    chk("R6 again", 64'(loop_again), 64'd1);
    issue(3'd5, ~LO, '0);
    chk("R6 mask zero", lane_mask, '0);
    chk("R6 again clr", 64'(loop_again), 64'd0);
    chk("R8 zero", 64'(mask_zero), 64'd1);
    body_len = 8'd11; #1;
    chk("R8 skip 11", 64'(skip_hint), 64'd0);
    body_len = 8'd12; #1;
    chk("R8 skip 12", 64'(skip_hint), 64'd1);
    issue(3'd2, ONES, '0);
    chk("R8 nonzero skip", 64'(skip_hint), 64'd0);
    chk("R8 zero clr", 64'(mask_zero), 64'd0);
    body_len = 8'd0;
  endtask

  task automatic t_loop_clear_by_other;
    issue(3'd5, 64'h1, '0);
    chk("R6 again set", 64'(loop_again), 64'd1);
    issue(3'd2, 64'h1, '0);
    chk("R6 again cleared", 64'(loop_again), 64'd0);
  endtask

  task automatic t_kill;
    issue(3'd6, 64'h0000_0000_7FFF_FFFF, '0);
    chk("R7 positive", lane_mask, ONES);
    issue(3'd6, 64'h0000_0000_8000_0000, '0);
    chk("R7 negative", lane_mask, '0);
    chk("R7 ret", res_data, '0);
    issue(3'd2, ONES, '0);
  endtask

  task automatic t_nop_hold;
    issue(3'd0, COND, '0);
    issue(3'd7, 64'h1234, 64'h5678);
    chk("R9 nop mask", lane_mask, COND);
    chk("R9 nop ret", res_data, COND);
    @(negedge clk); op_code = 3'd0; op_a = '0;
    repeat (3) @(negedge clk);
    chk("R9 idle mask", lane_mask, COND);
    chk("R9 idle ret", res_data, COND);
    issue(3'd2, ~COND, '0);
  endtask

  task automatic t_backpressure;
    @(negedge clk); res_ready = 1'b0;
    issue(3'd0, LO, '0);
    chk("R10 held valid", 64'(res_valid), 64'd1);
    chk("R10 ready low", 64'(op_ready), 64'd0);
    op_valid = 1'b1; op_code = 3'd6; op_a = ONES;
    repeat (2) @(negedge clk);
    op_valid = 1'b0;
    chk("R10 blocked mask", lane_mask, LO);
    chk("R10 held data", res_data, ~LO);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", 64'(res_valid), 64'd0);
    issue(3'd2, ONES, '0);
    chk("R10 resumed", lane_mask, ONES);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_if_else_end();
    t_breaks();
    t_loop();
    t_loop_clear_by_other();
    t_kill();
    t_nop_hold();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule